// File: doc/BRIEF.md
# Round-Robin Thread Slicer

This block shares one execution core among a fixed number of hardware threads. It keeps a saved context for every thread: a program counter, a bank of general registers, a set of condition flags and a halted mark. It also runs a per-slice instruction countdown. Each time the core retires an instruction, the block decides whether the running thread keeps the core. The slice can end because the countdown ran out, because the instruction was a yield, or because it was a halt.

A slice ending by countdown or yield first stores the live core context into the current thread's slot. It then picks the next runnable thread and presents that thread's stored context for the core to load. A halt marks the thread finished and moves on without storing anything. Once no runnable thread is left, the block raises a finished flag and keeps it.

The core holds still for every cycle in which `swap` is high. The restore outputs always show the stored context of the thread named by `tid`.

Top module: `thread_slicer`

## Requirements
- R1: After reset, every thread `t` has these stored values: PC equal to `LOAD_ADDR`; all registers zero except two; flags clear. Register index 1 holds that thread's initial argument from `INIT_ARG`. Register index 5 (the stack pointer) holds `MEM_TOP - t*STACK_STEP`. Thread 0 is restored first, with `swap` high for exactly one cycle after reset.
- R2: With random mode off, a slice lasts `interval` retired instructions. The retire that brings the countdown to zero starts a switch. Cycles in which `retire` is low do not count.
- R3: A retire with `op` = 2 (yield) starts a switch immediately, whatever the countdown shows.
- R4: A countdown or yield switch takes two cycles with `swap` high. In the first cycle the live PC, registers and flags are stored into the current thread's slot. In the second, `tid` names the new thread and the restore outputs show its stored context. Retires presented while `swap` is high are ignored.
- R5: The next thread is the first thread not halted, searching upward from the current index and wrapping to 0. The current thread is considered last, so a lone runnable thread that yields gets itself back.
- R6: A retire with `op` = 1 (halt) marks the current thread halted. `swap` is then high for a single cycle, during which the next thread is restored directly.
- R7: When the last runnable thread halts, `finished` rises and stays high, `swap` stays low, and later retires have no effect.
- R8: With `rand_en` high, each new slice length is drawn from 1 to `interval`.
- R9: An `interval` of 0 behaves as 1.
- R10: `op` = 0 and `op` = 3 both mean an ordinary instruction.
- R11: The countdown restarts at full length after every switch, including one caused by a yield.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire | input | 1 | One instruction retired this cycle |
| op | input | 2 | Kind of retired instruction: 0 plain, 1 halt, 2 yield, 3 plain |
| live_pc | input | PC_W | Core PC after the retired instruction |
| live_regs | input | NREGS*XLEN | Core registers, index r at bits r*XLEN |
| live_flags | input | NFLAGS | Core condition flags |
| interval | input | CNT_W | Slice length in instructions |
| rand_en | input | 1 | Draw slice lengths at random |
| tid | output | TID_W | Thread that owns the core |
| rst_pc | output | PC_W | Stored PC of thread `tid` |
| rst_regs | output | NREGS*XLEN | Stored registers of thread `tid` |
| rst_flags | output | NFLAGS | Stored flags of thread `tid` |
| swap | output | 1 | Switch in progress; core must stall and load restore outputs |
| finished | output | 1 | Every thread has halted |

## Verification
The inline assertions check, on every cycle, the properties that follow the control state. A store cycle is always followed by a restore cycle. The owner stays fixed in a running slice unless a halt arrives. A restored thread is never a halted one. Halt marks never clear, the countdown is never zero while a thread runs, and the finished flag sticks only when all threads are halted. Only the bench scenarios can show the data-level results: contexts are stored and returned intact after a full round, and the initial PCs, stack pointers and arguments are correct. They also show the exact slice lengths, that yields and halts are honoured, that a lone thread gets itself back, and that random slices fall inside their range.

// File: rtl/thread_slicer.sv
module thread_slicer #(
  parameter int NTHREADS   = 4,
  parameter int XLEN       = 16,
  parameter int PC_W       = 16,
  parameter int NREGS      = 7,
  parameter int NFLAGS     = 6,
  parameter int CNT_W      = 8,
  parameter int LOAD_ADDR  = 1000,
  parameter int MEM_TOP    = 16000,
  parameter int STACK_STEP = 1000,
  parameter int SP_IDX     = 5,
  parameter int ARG_IDX    = 1,
  parameter logic [NTHREADS*XLEN-1:0] INIT_ARG = '0,
  localparam int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int RW    = NREGS * XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire,
  input  logic [1:0]        op,
  input  logic [PC_W-1:0]   live_pc,
  input  logic [RW-1:0]     live_regs,
  input  logic [NFLAGS-1:0] live_flags,
  input  logic [CNT_W-1:0]  interval,
  input  logic              rand_en,
  output logic [TID_W-1:0]  tid,
  output logic [PC_W-1:0]   rst_pc,
  output logic [RW-1:0]     rst_regs,
  output logic [NFLAGS-1:0] rst_flags,
  output logic              swap,
  output logic              finished
);

  typedef enum logic [1:0] {S_RUN, S_SAVE, S_LOAD, S_DONE} st_t;

  st_t                 state;
  logic [CNT_W-1:0]    cnt;
  logic [15:0]         lfsr;
  logic [NTHREADS-1:0] done_q, done_eff, cur_hot;
  logic [TID_W-1:0]    nxt;
  logic [CNT_W-1:0]    ival, slice;
  logic [PC_W-1:0]     pc_s   [NTHREADS];
  logic [RW-1:0]       reg_s  [NTHREADS];
  logic [NFLAGS-1:0]   flg_s  [NTHREADS];

  function automatic logic [RW-1:0] boot_regs(int t);
    logic [RW-1:0] r;
    r = '0;
    r[ARG_IDX*XLEN +: XLEN] = INIT_ARG[t*XLEN +: XLEN];
    r[SP_IDX*XLEN +: XLEN]  = XLEN'(MEM_TOP - t*STACK_STEP);
    return r;
  endfunction

  wire take     = retire && (state == S_RUN);
  wire is_halt  = take && (op == 2'd1);
  wire is_yield = take && (op == 2'd2);

  assign cur_hot  = NTHREADS'(1) << tid;
  assign done_eff = done_q | (is_halt ? cur_hot : '0);
  assign ival     = (interval == '0) ? CNT_W'(1) : interval;
  assign slice    = rand_en ? CNT_W'(lfsr % 16'(ival)) + CNT_W'(1) : ival;

  always_comb begin
    int j;
    logic found;
    nxt   = tid;
    found = 1'b0;
    for (int k = 1; k <= NTHREADS; k++) begin
      j = (int'(tid) + k) % NTHREADS;
      if (!found && !done_eff[j]) begin
        nxt   = TID_W'(j);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_LOAD;
      tid    <= '0;
      done_q <= '0;
      cnt    <= CNT_W'(1);
      lfsr   <= 16'hACE1;
      for (int i = 0; i < NTHREADS; i++) begin
        pc_s[i]  <= PC_W'(LOAD_ADDR);
        reg_s[i] <= boot_regs(i);
        flg_s[i] <= '0;
      end
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (state)
        S_RUN: if (take) begin
          if (is_halt) begin
            done_q <= done_eff;
            if (&done_eff) state <= S_DONE;
            else begin
              tid   <= nxt;
              state <= S_LOAD;
            end
          end else if (is_yield || cnt <= CNT_W'(1)) begin
            state <= S_SAVE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_SAVE: begin
          pc_s[tid]  <= live_pc;
          reg_s[tid] <= live_regs;
          flg_s[tid] <= live_flags;
          tid        <= nxt;
          state      <= S_LOAD;
        end
        S_LOAD: begin
          cnt   <= slice;
          state <= S_RUN;
        end
        default: ;
      endcase
    end
  end

  assign rst_pc    = pc_s[tid];
  assign rst_regs  = reg_s[tid];
  assign rst_flags = flg_s[tid];
  assign swap      = (state == S_SAVE) || (state == S_LOAD);
  assign finished  = (state == S_DONE);

  AST_SAVE_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SAVE |=> state == S_LOAD); // R4
  AST_TID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && !is_halt) |=> $stable(tid)); // R5
  AST_RESTORE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LOAD |-> !done_q[tid]); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(done_q) & ~done_q) == '0)); // R6
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RUN |-> cnt != '0); // R2
  AST_FINISH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> finished); // R7
  AST_FINISH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> (&done_q && !swap)); // R7

endmodule

// File: tb/thread_slicer_test.sv
module thread_slicer_test;
  localparam int N = 4, XL = 16, NR = 7, NF = 6;

  logic clk = 1'b0, rst_n = 1'b0, retire = 1'b0, rand_en = 1'b0;
  logic [1:0] op = 2'd0;
  logic [15:0] live_pc = '0;
  logic [NR*XL-1:0] live_regs = '0;
  logic [NF-1:0] live_flags = '0;
  logic [7:0] interval = 8'd3;
  logic [1:0] tid;
  logic [15:0] rst_pc;
  logic [NR*XL-1:0] rst_regs;
  logic [NF-1:0] rst_flags;
  logic swap, finished;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  thread_slicer #(.NTHREADS(N), .INIT_ARG({16'd4, 16'd3, 16'd2, 16'd1})) uut (
    .clk, .rst_n, .retire, .op, .live_pc, .live_regs, .live_flags,
    .interval, .rand_en, .tid, .rst_pc, .rst_regs, .rst_flags, .swap, .finished);

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic eq(string tag, int act, int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic do_retire(logic [1:0] o);
    @(negedge clk); retire = 1'b1; op = o;
    @(negedge clk); retire = 1'b0; op = 2'd0;
  endtask

  task automatic set_live(logic [15:0] pc, logic [15:0] base, logic [NF-1:0] f);
    live_pc = pc; live_flags = f;
    for (int r = 0; r < NR; r++) live_regs[r*XL +: XL] = base + 16'(r);
  endtask

  task automatic chk_boot(int t, string tag);
    eq({tag, " tid"}, tid, t);
    eq({tag, " pc"}, rst_pc, 1000);
    eq({tag, " reg0"}, rst_regs[0 +: XL], 0);
    eq({tag, " arg"}, rst_regs[1*XL +: XL], t + 1);
    eq({tag, " sp"}, rst_regs[5*XL +: XL], 16000 - 1000*t);
    eq({tag, " flags"}, rst_flags, 0);
  endtask

  task automatic chk_saved(logic [15:0] pc, logic [15:0] base, logic [NF-1:0] f, string tag);
    eq({tag, " pc"}, rst_pc, pc);
    eq({tag, " flags"}, rst_flags, f);
    for (int r = 0; r < NR; r++) eq({tag, " reg"}, rst_regs[r*XL +: XL], base + 16'(r));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    eq("R1 swap at start", swap, 1);
    eq("R1 finished low", finished, 0);
    chk_boot(0, "R1 thread0");
    @(negedge clk);
    eq("R1 swap one cycle", swap, 0);
  endtask

  task automatic t_count_save;
    set_live(16'h1234, 16'h0100, 6'b101011);
    do_retire(2'd0); eq("R2 no swap after 1", swap, 0);
    @(negedge clk);
    do_retire(2'd3); eq("R10 op3 plain, no swap after 2", swap, 0);
    do_retire(2'd0); eq("R2 swap after 3", swap, 1); eq("R4 store cycle tid", tid, 0);
    retire = 1'b1; op = 2'd1;
    @(negedge clk); retire = 1'b0; op = 2'd0;
    eq("R4 second swap cycle", swap, 1);
    chk_boot(1, "R1 thread1");
    @(negedge clk);
    eq("R4 swap ends", swap, 0);
    eq("R4 halt during swap ignored", finished, 0);
  endtask

  task automatic t_yield_round;
    set_live(16'h2222, 16'h0200, 6'b010101);
    do_retire(2'd0); eq("R2 thread1 no swap", swap, 0);
    do_retire(2'd2); eq("R3 yield swaps", swap, 1);
    @(negedge clk); chk_boot(2, "R1 thread2");
    @(negedge clk);
    set_live(16'h3333, 16'h0300, 6'b000111);
    do_retire(2'd0); eq("R11 fresh slice 1", swap, 0);
    do_retire(2'd0); eq("R11 fresh slice 2", swap, 0);
    do_retire(2'd0); eq("R11 slice ends at 3", swap, 1);
    @(negedge clk); chk_boot(3, "R1 thread3");
    @(negedge clk);
    set_live(16'h4444, 16'h0400, 6'b111000);
    do_retire(2'd2);
    @(negedge clk); eq("R5 wrap to 0", tid, 0);
    chk_saved(16'h1234, 16'h0100, 6'b101011, "R4 thread0 restored");
    @(negedge clk);
  endtask

  task automatic t_halts;
    do_retire(2'd1);
    eq("R6 halt swap", swap, 1); eq("R6 next tid", tid, 1);
    chk_saved(16'h2222, 16'h0200, 6'b010101, "R4 thread1 restored");
    @(negedge clk); eq("R6 single swap cycle", swap, 0);
    do_retire(2'd1); eq("R6 halt thread1", tid, 2);
    @(negedge clk);
    chk_saved(16'h3333, 16'h0300, 6'b000111, "R4 thread2 restored");
    do_retire(2'd2);
    @(negedge clk); eq("R5 thread3", tid, 3);
    @(negedge clk);
    rand_en = 1'b1; interval = 8'd5;
    do_retire(2'd2);
    @(negedge clk); eq("R5 skip halted, wrap to 2", tid, 2);
    @(negedge clk);
  endtask

  task automatic t_random_zero;
    int n = 0;
    for (int k = 1; k <= 8; k++) begin
      do_retire(2'd0);
      n = k;
      if (swap) break;
    end
    chk(n >= 1 && n <= 5 && swap, "R8 random slice in 1..5", n, 5);
    rand_en = 1'b0; interval = 8'd0;
    @(negedge clk); eq("R5 thread3 again", tid, 3);
    @(negedge clk);
    do_retire(2'd0); eq("R9 interval 0 acts as 1", swap, 1);
    @(negedge clk); eq("R9 to thread2", tid, 2);
    @(negedge clk);
  endtask

  task automatic t_finish;
    do_retire(2'd1); eq("R6 halt thread2", tid, 3);
    @(negedge clk);
    do_retire(2'd2); eq("R5 lone yield swaps", swap, 1);
    @(negedge clk); eq("R5 lone thread gets itself", tid, 3);
    chk_saved(16'h4444, 16'h0400, 6'b111000, "R4 thread3 self");
    @(negedge clk);
    do_retire(2'd1);
    eq("R7 finished", finished, 1); eq("R7 no swap", swap, 0);
    do_retire(2'd2);
    eq("R7 finished holds", finished, 1); eq("R7 swap stays low", swap, 0);
    eq("R7 tid unchanged", tid, 3);
  endtask

  initial begin
    t_reset;
    t_count_save;
    t_yield_round;
    t_halts;
    t_random_zero;
    t_finish;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule